// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that exposes a bank of ten eight-bit control registers to an external bus master. The serial clock and data lines are sampled by the system clock through two-flop synchronizers. Start and stop conditions are recognised from data-line edges seen while the clock line is high. The target answers to one fixed seven-bit device address and drives the data line only low, through an open-drain output enable, to acknowledge bytes and to shift out read data.

A write transfer carries the device address, then a register sub-address, then one or more data bytes. Each data byte lands at the current register address, and the address then steps up by one. A read first sets the address with a short write, then issues a repeated start with the read bit set. Data bytes follow for as long as the master acknowledges them. The four-bit address counter stops at 0x0F instead of wrapping. Address 0x00 is a write-only soft-reset location: writing it clears every register, and the byte that follows it in the same transfer is discarded.

The register contents are presented in parallel on a flat output bus for the logic they configure.

Top module: `regbank_i2c_target`

## Requirements
- R1: The target acknowledges a first byte whose upper seven bits equal 1001101 (write byte 0x9A, read byte 0x9B). Any other address gets no acknowledge, and the rest of that transfer leaves the registers unchanged.
- R2: An acknowledge holds SDA low through the ninth SCL high phase. The target releases SDA only after SCL has gone low again.
- R3: In a write, the second byte's low nibble selects the register, and the third byte is stored there. Register n appears on cfg_o[8n-1 : 8n-8].
- R4: Each further data byte before a stop goes to the next address, and every written byte is acknowledged.
- R5: The address counter saturates at 0x0F. Bytes written or read past that point keep addressing 0x0F and never wrap to 0x00 or 0x01.
- R6: After a write of the sub-address and a repeated start with the read byte, the target shifts out the addressed register MSB first, one bit per SCL low phase.
- R7: During a read, a master acknowledge makes the target send the next register. A not-acknowledge ends the transfer with SDA released.
- R8: Writing address 0x00 returns registers 0x01 to 0x0A to 0x00. In the same transfer the next byte is discarded, and the byte after it is written to 0x01.
- R9: While rst_n is low, all registers read 0x00 and SDA is not driven.
- R10: Reads of 0x00 and of 0x0B to 0x0F return 0x00. Writes to 0x0B to 0x0F are acknowledged and dropped.
- R11: A stop ends any transfer and discards a partly received byte. A start at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset, restores register defaults |
| scl_i | input | 1 | Serial clock line from the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | When 1, pull the data line low |
| cfg_o | output | 80 | Registers 0x01 to 0x0A, register n in bits 8n-1 : 8n-8 |

## Verification
The bench goes after address saturation by writing and reading across 0x0E and 0x0F. A counter that wrapped would land on 0x00 and wipe the bank, or would read back register 0x01 as the fourth byte. It runs a soft-reset write followed by two more bytes: a design that kept the discarded byte would put it in 0x01, and one that skipped too much would leave 0x02 empty. It also sends a wrong device address, aborts a half-sent byte with a stop, and ends a read with a not-acknowledge. A target that acknowledged a foreign address, kept a partial byte, or kept driving SDA after the master's refusal shows up as wrong register contents or as a low bus line where a high one is expected.

// File: rtl/regbank_i2c_target.sv
module regbank_i2c_target #(
  parameter logic [6:0] DEV_ADDR = 7'b1001101,
  parameter int NREG = 11,
  parameter int AW   = 4,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  output logic [(NREG-1)*DW-1:0]   cfg_o
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_SUB, S_WR, S_RD} st_t;

  localparam logic [AW-1:0] TOP = '1;

  logic [SYNC:0] scl_sr, sda_sr;
  st_t           st;
  logic [3:0]    rcnt;
  logic [DW-1:0] sh, tx, rd_cur, rd_nxt;
  logic [AW-1:0] ptr, nptr;
  logic          skip, first_rd, mack;
  logic [DW-1:0] regs [1:NREG-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC-1:0], scl_i};
      sda_sr <= {sda_sr[SYNC-1:0], sda_i};
    end

  wire scl   = scl_sr[SYNC-1];
  wire scl_d = scl_sr[SYNC];
  wire sda   = sda_sr[SYNC-1];
  wire sda_d = sda_sr[SYNC];

  wire scl_rise = scl & ~scl_d;
  wire scl_fall = ~scl & scl_d;
  wire start_c  = scl & scl_d & sda_d & ~sda;
  wire stop_c   = scl & scl_d & ~sda_d & sda;

  wire byte_done = scl_fall && (rcnt == 4'd8) && !start_c && !stop_c;
  wire sub_load  = byte_done && (st == S_SUB);
  wire idle_w    = (st == S_IDLE);
  wire wr_hit    = byte_done && (st == S_WR) && !skip;
  wire wr_clr    = wr_hit && (ptr == '0);
  wire wr_en     = wr_hit && (ptr != '0) && (int'(ptr) < NREG);

  assign nptr = (ptr == TOP) ? ptr : ptr + 1'b1;

  always_comb begin
    rd_cur = '0;
    rd_nxt = '0;
    for (int i = 1; i < NREG; i++) begin
      if (ptr == AW'(i))  rd_cur = regs[i];
      if (nptr == AW'(i)) rd_nxt = regs[i];
    end
  end

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          regs[g] <= '0;
      else if (wr_clr)                     regs[g] <= '0;
      else if (wr_en && ptr == AW'(g))     regs[g] <= sh;
    assign cfg_o[(g-1)*DW +: DW] = regs[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_IDLE;
      rcnt     <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      skip     <= 1'b0;
      first_rd <= 1'b0;
      mack     <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_c) begin
      st       <= S_DEV;
      rcnt     <= '0;
      sda_oe   <= 1'b0;
      first_rd <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      rcnt   <= '0;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (rcnt < 4'd8)  sh   <= {sh[DW-2:0], sda};
        if (rcnt == 4'd8) mack <= ~sda;
        if (rcnt < 4'd9)  rcnt <= rcnt + 4'd1;
      end else if (scl_fall) begin
        if (rcnt == 4'd8) begin
          case (st)
            S_DEV:
              if (sh[DW-1:1] == DEV_ADDR) begin
                sda_oe   <= 1'b1;
                st       <= sh[0] ? S_RD : S_SUB;
                first_rd <= sh[0];
              end else begin
                st <= S_IDLE;
              end
            S_SUB: begin
              sda_oe <= 1'b1;
              ptr    <= sh[AW-1:0];
              skip   <= 1'b0;
              st     <= S_WR;
            end
            S_WR: begin
              sda_oe <= 1'b1;
              if (skip) skip <= 1'b0;
              else begin
                if (ptr == '0) skip <= 1'b1;
                ptr <= nptr;
              end
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (rcnt == 4'd9) begin
          rcnt   <= '0;
          sda_oe <= 1'b0;
          if (st == S_RD) begin
            if (first_rd) begin
              first_rd <= 1'b0;
              tx       <= rd_cur;
              sda_oe   <= ~rd_cur[DW-1];
            end else if (mack) begin
              ptr    <= nptr;
              tx     <= rd_nxt;
              sda_oe <= ~rd_nxt[DW-1];
            end else begin
              st <= S_IDLE;
            end
          end
        end else if (st == S_RD && rcnt != '0) begin
          tx     <= {tx[DW-2:0], 1'b0};
          sda_oe <= ~tx[DW-2];
        end
      end
    end

endmodule

module regbank_i2c_target_chk #(
  parameter int W  = 80,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input logic [W-1:0]  cfg_o,
  input logic [AW-1:0] ptr,
  input logic          sub_load,
  input logic          idle
);

  logic [1:0] c;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) c <= '1;
    else        c <= {c[0], scl_i};

  p_drive_on_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !c[1]);

  p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && c[1]) |=> sda_oe);

  p_ptr_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(ptr)) && !$past(sub_load)) |-> (&ptr));

  p_defaults_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_o == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe);

endmodule

bind regbank_i2c_target regbank_i2c_target_chk #(.W((NREG-1)*DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_o(cfg_o), .ptr(ptr), .sub_load(sub_load), .idle(idle_w)
);

// File: tb/sim_regbank_i2c_target.sv
module sim_regbank_i2c_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [79:0] cfg_o;
  wire  sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  regbank_i2c_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .cfg_o(cfg_o)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;
  bit last_hold, last_rel;
  logic [7:0] got_q[$], exp_q[$];
  string tag_q[$];

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] regv(int a);
    return cfg_o[(a-1)*8 +: 8];
  endfunction

  task automatic wt(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic wr_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    wr_bits(b, 8);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    ack = ~sda_line;
    wt(Q); scl_m = 1'b0; wt(1);
    last_hold = ~sda_line;
    wt(Q-1);
    last_rel = sda_line;
  endtask

  task automatic rd_byte(input bit mack);
    logic [7:0] b;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl_m = 1'b0;
    end
    got_q.push_back(b);
    wt(1);
    sda_m = ~mack; wt(Q-1); scl_m = 1'b1; wt(2*Q); scl_m = 1'b0; wt(1);
    sda_m = 1'b1;
  endtask

  task automatic expect_rd(string tag, logic [7:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic set_ptr(input logic [7:0] sub);
    bit a;
    i2c_start; wr_byte(8'h9A, a); wr_byte(sub, a);
  endtask

  initial begin : monitor
    forever begin
      wait (got_q.size() != 0);
      begin
        logic [7:0] g, e;
        string t;
        g = got_q.pop_front();
        e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hxx;
        t = (tag_q.size() != 0) ? tag_q.pop_front() : "R6 unexpected read";
        chk(t, {24'h0, g}, {24'h0, e});
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : main
    bit a;
    wt(5);
    chk("R9 cfg in reset", {16'h0, cfg_o[15:0]}, 32'h0);
    chk("R9 sda in reset", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    wt(Q);

    // R1 R3 R4 basic write with increment
    i2c_start;
    wr_byte(8'h9A, a);
    chk("R1 address ack", {31'h0, a}, 32'h1);
    chk("R2 held after fall", {31'h0, last_hold}, 32'h1);
    chk("R2 released later", {31'h0, last_rel}, 32'h1);
    wr_byte(8'h01, a);
    wr_byte(8'hA5, a); chk("R4 data ack", {31'h0, a}, 32'h1);
    wr_byte(8'h3C, a);
    wr_byte(8'h7E, a);
    i2c_stop;
    chk("R3 reg1", {24'h0, regv(1)}, 32'hA5);
    chk("R4 reg2", {24'h0, regv(2)}, 32'h3C);
    chk("R4 reg3", {24'h0, regv(3)}, 32'h7E);

    // R1 foreign address
    i2c_start;
    wr_byte(8'h9C, a);
    chk("R1 foreign nack", {31'h0, a}, 32'h0);
    wr_byte(8'h01, a);
    wr_byte(8'h00, a);
    i2c_stop;
    chk("R1 foreign no write", {24'h0, regv(1)}, 32'hA5);

    // R6 R7 read with repeated start
    set_ptr(8'h01);
    i2c_start; wr_byte(8'h9B, a);
    chk("R6 read addr ack", {31'h0, a}, 32'h1);
    expect_rd("R6 read reg1", 8'hA5);
    expect_rd("R7 read reg2", 8'h3C);
    expect_rd("R7 read reg3", 8'h7E);
    rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    wt(Q);
    chk("R7 released after nack", {31'h0, sda_line}, 32'h1);
    i2c_stop;

    // R10 unused addresses
    set_ptr(8'h0A);
    wr_byte(8'h11, a); wr_byte(8'h22, a);
    chk("R10 unused write ack", {31'h0, a}, 32'h1);
    i2c_stop;
    chk("R10 reg10", {24'h0, regv(10)}, 32'h11);
    chk("R10 reg9 untouched", {24'h0, regv(9)}, 32'h00);
    set_ptr(8'h09);
    i2c_start; wr_byte(8'h9B, a);
    expect_rd("R4 read reg9", 8'h00);
    expect_rd("R10 read reg10", 8'h11);
    expect_rd("R10 read 0x0B", 8'h00);
    rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    i2c_stop;
    set_ptr(8'h00);
    i2c_start; wr_byte(8'h9B, a);
    expect_rd("R10 read 0x00", 8'h00);
    rd_byte(1'b0);
    i2c_stop;

    // R5 saturation
    set_ptr(8'h0E);
    wr_byte(8'h55, a); wr_byte(8'h66, a); wr_byte(8'h77, a); wr_byte(8'h88, a);
    chk("R5 ack past top", {31'h0, a}, 32'h1);
    i2c_stop;
    chk("R5 no wrap reg1", {24'h0, regv(1)}, 32'hA5);
    chk("R5 no wrap reg10", {24'h0, regv(10)}, 32'h11);
    set_ptr(8'h0E);
    i2c_start; wr_byte(8'h9B, a);
    for (int k = 0; k < 4; k++) expect_rd("R5 read saturated", 8'h00);
    rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b1); rd_byte(1'b0);
    i2c_stop;

    // R8 soft reset with discarded byte
    set_ptr(8'h00);
    wr_byte(8'hFF, a); wr_byte(8'h77, a); wr_byte(8'h42, a); wr_byte(8'h43, a);
    i2c_stop;
    chk("R8 reg1 after skip", {24'h0, regv(1)}, 32'h42);
    chk("R8 reg2", {24'h0, regv(2)}, 32'h43);
    chk("R8 reg3 cleared", {24'h0, regv(3)}, 32'h00);
    chk("R8 reg10 cleared", {24'h0, regv(10)}, 32'h00);

    // R11 aborted byte
    set_ptr(8'h05);
    wr_bits(8'hF0, 4);
    i2c_stop;
    chk("R11 partial dropped", {24'h0, regv(5)}, 32'h00);
    set_ptr(8'h05);
    wr_byte(8'h99, a);
    i2c_stop;
    chk("R11 new transfer", {24'h0, regv(5)}, 32'h99);

    // R9 external reset
    rst_n = 1'b0; wt(3);
    chk("R9 reset clears", {31'h0, cfg_o != '0}, 32'h0);
    rst_n = 1'b1; wt(Q);

    wait (got_q.size() == 0);
    wt(2);
    chk("R6 all reads seen", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule